// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits next to a memory-mapped slave and decides whether each exclusive write may go ahead. It observes the read-address and write-address channels of the slave as valid/ready handshakes; a transfer counts only in a cycle where both valid and ready are high. The block never drives ready and never applies back-pressure: the slave keeps full control of its own stall behaviour, and the monitor only acts on the handshakes it sees. Each observed transfer carries an ID, a byte address and an exclusive flag.

An exclusive read reserves the address granule it touches for its ID. The table has a parameterised number of entries and holds one reservation per ID. Any write that reaches memory drops every reservation on the granule it touches. An exclusive write whose ID still holds a reservation on the target granule passes. The pass/fail decision, the write response code and a gated memory write enable come out combinationally in the handshake cycle. A failed exclusive write gets the normal OKAY code and must leave memory untouched. The slave can flag its own error on a write, which turns the response into a slave error. The block never produces the decode-error code (2'b11), which belongs to address decoding in the fabric.

Top module: `excl_monitor`

## Requirements
- R1: An exclusive read handshake (rd_valid & rd_ready & rd_excl) records its ID and the granule of its address, so that a later exclusive write with the same ID and granule passes.
- R2: The table holds at most one reservation per ID. A new exclusive read with an ID already present replaces that entry's granule, and an exclusive write to the old granule then fails.
- R3: A non-exclusive write handshake without error drives wr_mem_en=1 and wr_resp=2'b00. It removes every reservation, from any ID, on its granule.
- R4: An exclusive write handshake without error whose ID holds a reservation on its granule drives wr_pass=1, wr_mem_en=1 and wr_resp=2'b01 (EXOKAY).
- R5: An exclusive write handshake without a matching reservation drives wr_pass=0, wr_mem_en=0 and wr_resp=2'b00 (OKAY), and leaves the table unchanged.
- R6: A passing exclusive write removes all reservations on its granule, including its own. A second exclusive write without a new exclusive read fails.
- R7: If an exclusive read and a memory-updating write to the same granule handshake in the same cycle, the write's invalidation happens first and the read's reservation survives.
- R8: A write handshake with wr_err=1 drives wr_resp=2'b10 (SLVERR), wr_mem_en=0 and wr_pass=0, and leaves the table unchanged.
- R9: An exclusive read takes a slot in this order: the entry already holding its ID; otherwise the lowest-numbered free entry; otherwise the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each eviction. ID match and free state are judged on the table contents at the start of the cycle.
- R10: Addresses are compared at a granule of 2^GRANULE_LG2 bytes. Addresses that differ only in the low GRANULE_LG2 bits match.
- R11: rd_resp is 2'b01 during an exclusive read handshake and 2'b00 otherwise. After reset the table is empty.
- R12: wr_pass, wr_mem_en and wr_resp are valid in the same cycle as the write handshake. Without a write handshake they are 0, 0 and 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read-address valid seen at the slave |
| rd_ready | input | 1 | Read-address ready from the slave |
| rd_id | input | ID_W | Read transaction ID |
| rd_addr | input | ADDR_W | Read byte address |
| rd_excl | input | 1 | Read is exclusive |
| wr_valid | input | 1 | Write-address valid seen at the slave |
| wr_ready | input | 1 | Write-address ready from the slave |
| wr_id | input | ID_W | Write transaction ID |
| wr_addr | input | ADDR_W | Write byte address |
| wr_excl | input | 1 | Write is exclusive |
| wr_err | input | 1 | Slave flags an error on this write |
| wr_pass | output | 1 | Exclusive write succeeds |
| wr_mem_en | output | 1 | Memory write permitted |
| wr_resp | output | 2 | Write response code |
| rd_resp | output | 2 | Read response code |

## Verification
The bench drives a directed and a random mix and goes after the following cases. A reservation replaced by a second read of the same ID: a design that keeps both would pass the stale write. A plain write from another ID: one that ignores it would let a stale exclusive write through. The read/write collision on one granule: applying the read first would wrongly fail the next exclusive write. Repeating an exclusive write after it passes: a design that keeps the entry would pass twice. Slave errors: a wrong design would corrupt memory or clear a reservation. With more IDs than entries, eviction order is compared every cycle against a behavioural table, so a wrong victim choice shows up as a later pass/fail mismatch.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/excl_entry.sv
// One reservation slot: valid flag, owner ID and granule tag.
module excl_entry #(
  parameter int ID_W  = 4,
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [ID_W-1:0]  ld_id_i,
  input  logic [TAG_W-1:0] ld_tag_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [ID_W-1:0]  rd_id_i,
  output logic             vld_o,
  output logic             tag_hit_o,
  output logic             full_hit_o,
  output logic             id_hit_o
);
  logic             vld_q;
  logic [ID_W-1:0]  id_q;
  logic [TAG_W-1:0] tag_q;

  // load wins over clear: write invalidation is ordered before the read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      id_q  <= '0;
      tag_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      id_q  <= ld_id_i;
      tag_q <= ld_tag_i;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o      = vld_q;
  assign tag_hit_o  = vld_q && (tag_q == wr_tag_i);
  assign full_hit_o = tag_hit_o && (id_q == wr_id_i);
  assign id_hit_o   = vld_q && (id_q == rd_id_i);
endmodule

// File: rtl/excl_alloc.sv
// Slot choice for a new reservation: ID hit, lowest free, round-robin victim.
module excl_alloc #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [N-1:0] vld_i,
  input  logic [N-1:0] idhit_i,
  output logic [N-1:0] sel_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q;
  logic [N-1:0]     free_sel;
  logic             any_free;
  logic             evict;

  always_comb begin
    free_sel = '0;
    any_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!vld_i[i] && !any_free) begin
        free_sel[i] = 1'b1;
        any_free    = 1'b1;
      end
    end
  end

  assign evict = req_i && !(|idhit_i) && !any_free;

  always_comb begin
    sel_o = '0;
    if (|idhit_i)      sel_o = idhit_i;
    else if (any_free) sel_o = free_sel;
    else               sel_o[rr_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rr_q <= '0;
    else if (evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/excl_decide.sv
// Outcome of an observed write: pass flag, memory enable, response code.
module excl_decide
  import excl_mon_pkg::*;
(
  input  logic       hs_i,
  input  logic       excl_i,
  input  logic       err_i,
  input  logic       hit_i,
  output logic       pass_o,
  output logic       mem_en_o,
  output logic [1:0] resp_o
);
  resp_e resp;

  always_comb begin
    pass_o   = 1'b0;
    mem_en_o = 1'b0;
    resp     = RESP_OKAY;
    if (hs_i) begin
      if (err_i) begin
        resp = RESP_SLVERR;
      end else if (excl_i) begin
        pass_o   = hit_i;
        mem_en_o = hit_i;
        resp     = hit_i ? RESP_EXOKAY : RESP_OKAY;
      end else begin
        mem_en_o = 1'b1;
      end
    end
  end

  assign resp_o = resp;
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ID_W        = 4,
  parameter int ADDR_W      = 32,
  parameter int GRANULE_LG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_ready,
  input  logic [ID_W-1:0]   rd_id,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_excl,
  input  logic              wr_valid,
  input  logic              wr_ready,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_excl,
  input  logic              wr_err,
  output logic              wr_pass,
  output logic              wr_mem_en,
  output logic [1:0]        wr_resp,
  output logic [1:0]        rd_resp
);
  localparam int TAG_W = ADDR_W - GRANULE_LG2;

  logic             rd_hs, wr_hs, rd_alloc;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic [NUM_ENTRIES-1:0] vld, tag_hit, full_hit, id_hit, sel;
  logic             unused_low;

  assign rd_hs    = rd_valid && rd_ready;
  assign wr_hs    = wr_valid && wr_ready;
  assign rd_alloc = rd_hs && rd_excl;
  assign rd_tag   = rd_addr[ADDR_W-1:GRANULE_LG2];
  assign wr_tag   = wr_addr[ADDR_W-1:GRANULE_LG2];
  assign unused_low = ^{rd_addr[GRANULE_LG2-1:0], wr_addr[GRANULE_LG2-1:0]};

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    excl_entry #(.ID_W(ID_W), .TAG_W(TAG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (wr_mem_en && tag_hit[g]),
      .load_i    (rd_alloc && sel[g]),
      .ld_id_i   (rd_id),
      .ld_tag_i  (rd_tag),
      .wr_id_i   (wr_id),
      .wr_tag_i  (wr_tag),
      .rd_id_i   (rd_id),
      .vld_o     (vld[g]),
      .tag_hit_o (tag_hit[g]),
      .full_hit_o(full_hit[g]),
      .id_hit_o  (id_hit[g])
    );
  end

  excl_alloc #(.N(NUM_ENTRIES)) u_alloc (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (rd_alloc),
    .vld_i  (vld),
    .idhit_i(id_hit),
    .sel_o  (sel)
  );

  excl_decide u_dec (
    .hs_i    (wr_hs),
    .excl_i  (wr_excl),
    .err_i   (wr_err),
    .hit_i   (|full_hit),
    .pass_o  (wr_pass),
    .mem_en_o(wr_mem_en),
    .resp_o  (wr_resp)
  );

  assign rd_resp = rd_alloc ? RESP_EXOKAY : RESP_OKAY;
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ID_W        = 4,
  parameter int ADDR_W      = 32,
  parameter int GRANULE_LG2 = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ID_W-1:0]   rd_id,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_excl,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ID_W-1:0]   wr_id,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_excl,
  input logic              wr_err,
  input logic              wr_pass,
  input logic              wr_mem_en,
  input logic [1:0]        wr_resp,
  input logic [1:0]        rd_resp
);
  logic armed;
  logic wr_hs, rd_hs, same_gran;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end
  assign wr_hs = wr_valid && wr_ready;
  assign rd_hs = rd_valid && rd_ready;
  assign same_gran = rd_addr[ADDR_W-1:GRANULE_LG2] == wr_addr[ADDR_W-1:GRANULE_LG2];

  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && wr_excl && !wr_pass) |-> (!wr_mem_en && wr_resp != 2'b01)); // R5

  AST_PASS_EXOKAY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass |-> (wr_hs && wr_excl && !wr_err && wr_mem_en && wr_resp == 2'b01)); // R4

  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !wr_excl && !wr_err) |-> (wr_mem_en && wr_resp == 2'b00)); // R3

  AST_SLVERR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && wr_err) |-> (!wr_mem_en && !wr_pass && wr_resp == 2'b10)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hs |-> (!wr_pass && !wr_mem_en && wr_resp == 2'b00)); // R12

  AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp == ((rd_hs && rd_excl) ? 2'b01 : 2'b00)); // R11

  AST_NO_DOUBLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_hs && wr_excl && $past(wr_pass) && !$past(rd_hs && rd_excl)
     && wr_id == $past(wr_id)
     && wr_addr[ADDR_W-1:GRANULE_LG2] == $past(wr_addr[ADDR_W-1:GRANULE_LG2]))
    |-> !wr_pass); // R6

  AST_WRITE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rd_hs && rd_excl && wr_hs && !wr_excl && !wr_err && same_gran)
     && wr_hs && wr_excl && !wr_err && wr_id == $past(rd_id)
     && wr_addr[ADDR_W-1:GRANULE_LG2] == $past(rd_addr[ADDR_W-1:GRANULE_LG2]))
    |-> wr_pass); // R7
endmodule

bind excl_monitor excl_monitor_chk #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .GRANULE_LG2(GRANULE_LG2)
) u_chk (.*);

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
  localparam int N = 4;
  localparam int IW = 4;
  localparam int AW = 32;
  localparam int GL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 0, rd_ready = 0, rd_excl = 0;
  logic [IW-1:0] rd_id = '0;
  logic [AW-1:0] rd_addr = '0;
  logic wr_valid = 0, wr_ready = 0, wr_excl = 0, wr_err = 0;
  logic [IW-1:0] wr_id = '0;
  logic [AW-1:0] wr_addr = '0;
  logic wr_pass, wr_mem_en;
  logic [1:0] wr_resp, rd_resp;

  int tests = 0;
  int fails = 0;

  // behavioural reference table
  bit m_vld[N];
  int m_id[N];
  longint m_tag[N];
  int m_rr;

  always #10 clk = ~clk;

  excl_monitor #(.NUM_ENTRIES(N), .ID_W(IW), .ADDR_W(AW), .GRANULE_LG2(GL)) dut (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_id(rd_id), .rd_addr(rd_addr), .rd_excl(rd_excl),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_id(wr_id), .wr_addr(wr_addr), .wr_excl(wr_excl),
    .wr_err(wr_err), .wr_pass(wr_pass), .wr_mem_en(wr_mem_en), .wr_resp(wr_resp), .rd_resp(rd_resp)
  );

  function automatic longint gran(input logic [AW-1:0] a);
    return longint'(a >> GL);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_id[i] = 0; m_tag[i] = 0; end
    m_rr = 0;
  endtask

  task automatic step(input string tag,
                      input bit rv, input bit rr, input int rid, input logic [AW-1:0] ra, input bit rx,
                      input bit wv, input bit wrd, input int wid, input logic [AW-1:0] wa,
                      input bit wx, input bit we);
    bit whs, rhs, hit, e_pass, e_en;
    bit snap_v[N];
    int snap_id[N];
    int slot;
    logic [1:0] e_resp, e_rresp;
    rd_valid = rv; rd_ready = rr; rd_id = IW'(rid); rd_addr = ra; rd_excl = rx;
    wr_valid = wv; wr_ready = wrd; wr_id = IW'(wid); wr_addr = wa; wr_excl = wx; wr_err = we;
    #2;
    whs = wv && wrd;
    rhs = rv && rr;
    hit = 0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_id[i] == wid && m_tag[i] == gran(wa)) hit = 1;
    e_pass = whs && wx && !we && hit;
    e_en   = whs && !we && (!wx || hit);
    e_resp = !whs ? 2'b00 : we ? 2'b10 : e_pass ? 2'b01 : 2'b00;
    e_rresp = (rhs && rx) ? 2'b01 : 2'b00;
    tests++;
    if (wr_pass !== e_pass || wr_mem_en !== e_en || wr_resp !== e_resp || rd_resp !== e_rresp) begin
      fails++;
      $display("FAIL %s t=%0t pass/en/resp/rresp actual %b/%b/%b/%b expected %b/%b/%b/%b",
               tag, $time, wr_pass, wr_mem_en, wr_resp, rd_resp, e_pass, e_en, e_resp, e_rresp);
    end
    for (int i = 0; i < N; i++) begin snap_v[i] = m_vld[i]; snap_id[i] = m_id[i]; end
    if (e_en)
      for (int i = 0; i < N; i++) if (m_tag[i] == gran(wa)) m_vld[i] = 0;
    if (rhs && rx) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (slot < 0 && snap_v[i] && snap_id[i] == rid) slot = i;
      for (int i = 0; i < N; i++) if (slot < 0 && !snap_v[i]) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
      m_vld[slot] = 1; m_id[slot] = rid; m_tag[slot] = gran(ra);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic xrd(input string tag, input int id, input logic [AW-1:0] a);
    step(tag, 1, 1, id, a, 1, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic xwr(input string tag, input int id, input logic [AW-1:0] a, input bit x, input bit e);
    step(tag, 0, 0, 0, 0, 0, 1, 1, id, a, x, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 R12: reset state, idle outputs quiet
    step("R12_idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    xwr("R11_empty_after_reset", 1, 32'h100, 1, 0);
    // R1 R10 R4 R6
    xrd("R11_rd_resp", 1, 32'h100);
    xwr("R10_R4_granule_pass", 1, 32'h104, 1, 0);
    xwr("R6_second_fails", 1, 32'h100, 1, 0);
    // R2 replacement
    xrd("R1_rd", 2, 32'h200);
    xrd("R2_replace", 2, 32'h300);
    xwr("R2_old_fails", 2, 32'h200, 1, 0);
    xwr("R2_new_passes", 2, 32'h300, 1, 0);
    // R3 other ID plain write cancels
    xrd("R1_rd3", 3, 32'h400);
    xwr("R3_plain_write", 5, 32'h404, 0, 0);
    xwr("R3_cancelled", 3, 32'h400, 1, 0);
    // R8 slave error leaves reservation
    xrd("R1_rd4", 4, 32'h500);
    xwr("R8_slverr", 6, 32'h500, 0, 1);
    xwr("R8_slverr_excl", 4, 32'h500, 1, 1);
    xwr("R8_still_reserved", 4, 32'h500, 1, 0);
    // R7 same-cycle read and write on one granule
    step("R7_collide", 1, 1, 6, 32'h600, 1, 1, 1, 7, 32'h602, 0, 0);
    xwr("R7_survives", 6, 32'h600, 1, 0);
    // R5 failed write changes nothing
    xrd("R1_rd7", 1, 32'h700);
    xwr("R5_wrong_id", 2, 32'h700, 1, 0);
    xwr("R5_owner_passes", 1, 32'h700, 1, 0);
    // R12 no handshake while not ready
    xrd("R1_rd8", 3, 32'h800);
    step("R12_not_ready", 0, 0, 0, 0, 0, 1, 0, 3, 32'h800, 1, 0);
    xwr("R12_then_pass", 3, 32'h800, 1, 0);
    // R9 fill and evict
    for (int k = 0; k < 6; k++) xrd("R9_fill", 8 + k, 32'h900 + 32'(k) * 8);
    for (int k = 0; k < 6; k++) xwr("R9_probe", 8 + k, 32'h900 + 32'(k) * 8, 1, 0);
    // random mix, model compared every cycle
    for (int k = 0; k < 3000; k++) begin
      step("R9_R2_R3_random",
           1'($urandom_range(1)), 1'($urandom_range(1)), int'($urandom_range(5)),
           32'h1000 + 32'($urandom_range(3)) * 8 + 32'($urandom_range(7)), 1'($urandom_range(3) != 0),
           1'($urandom_range(1)), 1'($urandom_range(1)), int'($urandom_range(5)),
           32'h1000 + 32'($urandom_range(3)) * 8 + 32'($urandom_range(7)), 1'($urandom_range(2) != 0),
           1'($urandom_range(9) == 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule